// File: doc/BRIEF.md
# Power Mode Transition Sequencer

This block sits in the power controller. It watches an activity hint vector that arrives from a clustered compute domain on a foreign clock, and it drives a four-phase power mode request handshake back toward that domain. Every hint bit crosses into the controller clock through its own flop chain. Because the bits are synchronized one by one, a change of several bits at once can show up briefly as a value that was never driven.

The hint only names the lowest power mode the domain can tolerate. It says nothing about whether a move from the present mode is legal. The sequencer decodes that minimum mode and compares it with the mode it has recorded as current. When the direct move is not legal, it reaches the target through ON, one completed handshake at a time.

A denied request leaves the recorded mode as it was. An accepted request makes the requested mode current. The target is re-read only while the sequencer is idle. A transient hint can therefore cost extra legal steps, but it can never produce an illegal request.

Top module: `pms_sequencer`

## Requirements
- R1: While reset is asserted and after its release, `preq` is low, `cur_mode` reads ON and `pstate` reads ON. Mode encodings are OFF=2'b00, MEM_RET=2'b01, FUNC_RET=2'b10, ON=2'b11.
- R2: The target mode comes from the synchronized hint. Bit 2 set gives ON. Otherwise bit 1 set gives FUNC_RET. Otherwise bit 0 set gives MEM_RET. No bit set gives OFF.
- R3: Every request is legal. Either the requested mode or `cur_mode` is ON, and the requested mode differs from `cur_mode`.
- R4: When neither the current mode nor the target is ON, the sequencer first requests ON and then requests the target. For example, FUNC_RET with a MEM_RET target issues ON and then MEM_RET.
- R5: `pstate` is driven at least one cycle before `preq` rises and holds while `preq` is high. `preq` falls on the first clock edge at which `paccept` or `pdeny` is seen high.
- R6: A new request rises only after both `paccept` and `pdeny` have returned low.
- R7: When `paccept` is seen with `preq` high, `cur_mode` takes the requested mode on the same edge that `preq` falls.
- R8: A denied request leaves `cur_mode` unchanged. The sequencer then re-evaluates the latest hint and requests again if the target still differs.
- R9: A hint that passes through intermediate values, including a brief OFF during a FUNC_RET to MEM_RET change, still ends with `cur_mode` equal to the final target. Once that is reached, no further request is made.
- R10: A hint change that arrives while a step is in flight takes effect only after that step completes. The next step is planned from the new target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low reset |
| hint_async | input | 3 | Activity hint from the domain, asynchronous to clk |
| paccept | input | 1 | Domain accepts the pending request |
| pdeny | input | 1 | Domain refuses the pending request |
| preq | output | 1 | Power mode request strobe |
| pstate | output | 2 | Requested power mode |
| cur_mode | output | 2 | Mode last accepted by the domain |

## Verification
The hardest case to reach from the ports is a step that is in flight when the hint moves, so that the re-plan after completion must use a different target than the one that started the sequence. The bench reaches it by stretching the responder's accept delay to ten cycles. It waits until `preq` is seen high on a FUNC_RET to ON step, then changes the hint, and checks that the follow-up request names the new target. The glitch case is produced the same way: the hint bits are changed a few cycles apart, so a transient OFF is synchronized before the final MEM_RET value arrives.

// File: rtl/pms_pkg.sv
package pms_pkg;

    localparam int HINT_W = 3;
    localparam int MODE_W = 2;
    // reset value of the synchronized hint: "ON needed"
    localparam logic [HINT_W-1:0] HINT_RST = 3'b100;

    typedef enum logic [MODE_W-1:0] {
        PM_OFF  = 2'b00,
        PM_MRET = 2'b01,
        PM_FRET = 2'b10,
        PM_ON   = 2'b11
    } pmode_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_SETUP,
        SQ_WAIT,
        SQ_DONE
    } sq_state_e;

    typedef struct packed {
        sq_state_e st;
        pmode_e    pstate;
        pmode_e    cur;
        logic      preq;
    } sq_regs_t;

endpackage

// File: rtl/pms_bit_sync.sv
module pms_bit_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/pms_hint_decode.sv
module pms_hint_decode
    import pms_pkg::*;
(
    input  logic [HINT_W-1:0] hint,
    output pmode_e            target
);
    // highest demanded level wins
    always_comb begin
        if (hint[2])      target = PM_ON;
        else if (hint[1]) target = PM_FRET;
        else if (hint[0]) target = PM_MRET;
        else              target = PM_OFF;
    end
endmodule

// File: rtl/pms_step_plan.sv
module pms_step_plan
    import pms_pkg::*;
(
    input  pmode_e cur,
    input  pmode_e target,
    output logic   move,
    output pmode_e step
);
    logic direct_ok;

    always_comb begin
        direct_ok = (cur == PM_ON) || (target == PM_ON);
        move      = (cur != target);
        step      = direct_ok ? target : PM_ON;
    end
endmodule

// File: rtl/pms_sequencer.sv
module pms_sequencer
    import pms_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HINT_W-1:0] hint_async,
    input  logic              paccept,
    input  logic              pdeny,
    output logic              preq,
    output logic [MODE_W-1:0] pstate,
    output logic [MODE_W-1:0] cur_mode
);
    logic [HINT_W-1:0] hint_sync;
    pmode_e            target;
    pmode_e            step;
    logic              move;
    sq_regs_t          d, q;

    for (genvar i = 0; i < HINT_W; i++) begin : g_sync
        pms_bit_sync #(
            .STAGES  (SYNC_STAGES),
            .RST_VAL (HINT_RST[i])
        ) i_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (hint_async[i]),
            .dout  (hint_sync[i])
        );
    end

    pms_hint_decode i_dec (
        .hint   (hint_sync),
        .target (target)
    );

    pms_step_plan i_plan (
        .cur    (q.cur),
        .target (target),
        .move   (move),
        .step   (step)
    );

    always_comb begin
        d = q;
        unique case (q.st)
            SQ_IDLE: begin
                if (move) begin
                    d.pstate = step;
                    d.st     = SQ_SETUP;
                end
            end
            SQ_SETUP: begin
                d.preq = 1'b1;
                d.st   = SQ_WAIT;
            end
            SQ_WAIT: begin
                if (paccept) begin
                    d.preq = 1'b0;
                    d.cur  = q.pstate;
                    d.st   = SQ_DONE;
                end else if (pdeny) begin
                    d.preq = 1'b0;
                    d.st   = SQ_DONE;
                end
            end
            SQ_DONE: begin
                if (!paccept && !pdeny) d.st = SQ_IDLE;
            end
            default: d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st     <= SQ_IDLE;
            q.pstate <= PM_ON;
            q.cur    <= PM_ON;
            q.preq   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign preq     = q.preq;
    assign pstate   = q.pstate;
    assign cur_mode = q.cur;

    // R3: a request that goes out is legal with respect to the recorded mode
    a_r3_legal_request: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(preq) |-> ((pstate == PM_ON) || (cur_mode == PM_ON)) && (pstate != cur_mode));

    // R5: mode is set up before the strobe rises
    a_r5_setup_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(preq) |-> $stable(pstate));

    // R5: mode holds while the strobe is high
    a_r5_pstate_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (preq && $past(preq)) |-> $stable(pstate));

    // R5: strobe drops after a response
    a_r5_drop_on_resp: assert property (@(posedge clk) disable iff (!rst_n)
        (preq && (paccept || pdeny)) |=> !preq);

    // R6: no new request while a response is still high
    a_r6_wait_release: assert property (@(posedge clk) disable iff (!rst_n)
        (!preq && (paccept || pdeny)) |=> !preq);

    // R7: accept records the requested mode
    a_r7_accept_records: assert property (@(posedge clk) disable iff (!rst_n)
        (preq && paccept) |=> (cur_mode == $past(pstate)));

    // R8: deny keeps the recorded mode
    a_r8_deny_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (preq && pdeny && !paccept) |=> $stable(cur_mode));

endmodule

// File: tb/test_pms_sequencer.sv
module test_pms_sequencer;

    localparam logic [1:0] M_OFF  = 2'b00;
    localparam logic [1:0] M_MRET = 2'b01;
    localparam logic [1:0] M_FRET = 2'b10;
    localparam logic [1:0] M_ON   = 2'b11;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] hint_async = 3'b100;
    logic       paccept = 1'b0;
    logic       pdeny = 1'b0;
    logic       preq;
    logic [1:0] pstate;
    logic [1:0] cur_mode;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    logic finished = 1'b0;

    // responder control: 0 random, 1 always deny, 2 always accept
    int resp_mode = 2;
    int resp_dly = -1;       // -1 random 0..3, otherwise fixed
    logic [1:0] model_cur = 2'b11;
    logic [1:0] log_q [0:15];
    int log_n = 0;

    always #2.5 clk = ~clk;

    pms_sequencer i_pms_sequencer (
        .clk        (clk),
        .rst_n      (rst_n),
        .hint_async (hint_async),
        .paccept    (paccept),
        .pdeny      (pdeny),
        .preq       (preq),
        .pstate     (pstate),
        .cur_mode   (cur_mode)
    );

    function automatic logic [1:0] f_target(input logic [2:0] h);
        if (h[2])      return M_ON;
        else if (h[1]) return M_FRET;
        else if (h[0]) return M_MRET;
        else           return M_OFF;
    endfunction

    function automatic logic f_legal(input logic [1:0] from, input logic [1:0] to);
        return ((from == M_ON) || (to == M_ON)) && (from != to);
    endfunction

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // domain-side responder with its own mode model
    initial begin
        logic [1:0] req;
        int n;
        logic acc;
        forever begin
            @(negedge clk);
            if (rst_n && preq) begin
                req = pstate;
                if (log_n < 16) log_q[log_n] = req;
                log_n++;
                chk(f_legal(model_cur, req), "R3 legal request", req, model_cur);
                n = (resp_dly < 0) ? int'($urandom % 4) : resp_dly;
                for (int i = 0; i < n; i++) begin
                    @(negedge clk);
                    chk(pstate == req, "R5 pstate hold", pstate, req);
                end
                if (resp_mode == 1)      acc = 1'b0;
                else if (resp_mode == 2) acc = 1'b1;
                else                     acc = ($urandom % 5) != 0;
                paccept = acc;
                pdeny   = !acc;
                @(negedge clk);
                chk(preq == 1'b0, "R5 preq drop", preq, 0);
                if (acc) model_cur = req;
                if (acc) chk(cur_mode == model_cur, "R7 accept records", cur_mode, model_cur);
                else     chk(cur_mode == model_cur, "R8 deny keeps", cur_mode, model_cur);
                n = int'($urandom % 4);
                for (int i = 0; i < n; i++) begin
                    @(negedge clk);
                    chk(preq == 1'b0, "R6 wait release", preq, 0);
                end
                paccept = 1'b0;
                pdeny   = 1'b0;
            end
        end
    end

    // settle until cur_mode reaches exp, then require quiet
    task automatic settle(input logic [1:0] exp, input string tag);
        int n = 0;
        while (n < 600 && !(cur_mode == exp && !preq && !paccept && !pdeny)) begin
            @(negedge clk);
            n++;
        end
        chk(cur_mode == exp, tag, cur_mode, exp);
        wait_cyc(8);
        chk(!preq && cur_mode == exp, {tag, " quiet"}, cur_mode, exp);
    endtask

    task automatic drive_hint(input logic [2:0] h);
        @(negedge clk);
        hint_async = h;
    endtask

    // watchdog
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000 && !finished) begin
                bad++;
                total++;
                $display("FAIL watchdog act=%0d exp=%0d", cycles, 150000);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        logic [2:0] h;
        void'($urandom(32'd4242));

        // R1 reset values
        wait_cyc(3);
        chk(preq == 1'b0, "R1 reset preq", preq, 0);
        chk(cur_mode == M_ON, "R1 reset cur_mode", cur_mode, M_ON);
        chk(pstate == M_ON, "R1 reset pstate", pstate, M_ON);
        rst_n = 1'b1;
        wait_cyc(10);
        chk(preq == 1'b0 && cur_mode == M_ON, "R1 idle after reset", cur_mode, M_ON);

        // R2 decode each target from ON
        drive_hint(3'b000); settle(M_OFF, "R2 target OFF");
        drive_hint(3'b011); settle(M_FRET, "R2 target FRET via ON");
        drive_hint(3'b101); settle(M_ON, "R2 target ON");
        drive_hint(3'b001); settle(M_MRET, "R2 target MRET");
        drive_hint(3'b100); settle(M_ON, "R2 back to ON");

        // R4 FUNC_RET -> MEM_RET goes through ON
        drive_hint(3'b010); settle(M_FRET, "R4 reach FRET");
        log_n = 0;
        drive_hint(3'b001); settle(M_MRET, "R4 reach MRET");
        chk(log_n == 2, "R4 step count", log_n, 2);
        chk(log_q[0] == M_ON, "R4 first step ON", log_q[0], M_ON);
        chk(log_q[1] == M_MRET, "R4 second step MRET", log_q[1], M_MRET);

        // R9 glitched hint: FUNC_RET -> transient OFF -> MEM_RET
        drive_hint(3'b010); settle(M_FRET, "R9 reach FRET");
        resp_dly = 10;
        log_n = 0;
        drive_hint(3'b000);
        wait_cyc(5);
        drive_hint(3'b001);
        settle(M_MRET, "R9 glitch converge");
        chk(log_q[0] == M_ON, "R9 first step ON", log_q[0], M_ON);
        chk(log_q[1] == M_MRET, "R9 second step MRET", log_q[1], M_MRET);

        // R10 hint changes while a step is in flight
        drive_hint(3'b010); settle(M_FRET, "R10 reach FRET");
        log_n = 0;
        drive_hint(3'b001);
        while (!preq) @(negedge clk);
        hint_async = 3'b000;
        settle(M_OFF, "R10 final OFF");
        chk(log_n == 2, "R10 step count", log_n, 2);
        chk(log_q[0] == M_ON, "R10 in-flight step ON", log_q[0], M_ON);
        chk(log_q[1] == M_OFF, "R10 replanned OFF", log_q[1], M_OFF);
        resp_dly = -1;

        // R8 deny keeps mode and retries
        drive_hint(3'b100); settle(M_ON, "R8 reach ON");
        resp_mode = 1;
        log_n = 0;
        drive_hint(3'b000);
        wait_cyc(60);
        chk(cur_mode == M_ON, "R8 deny holds ON", cur_mode, M_ON);
        chk(log_n >= 2, "R8 retry after deny", log_n, 2);
        resp_mode = 2;
        settle(M_OFF, "R8 accept after retries");

        // random hints, staggered bit changes, random accept/deny
        resp_mode = 0;
        for (int it = 0; it < 200; it++) begin
            h = 3'($urandom);
            if ($urandom % 3 == 0) begin
                for (int b = 0; b < 3; b++) begin
                    @(negedge clk);
                    hint_async[b] = h[b];
                end
            end else begin
                drive_hint(h);
            end
            wait_cyc(int'($urandom % 40));
        end
        resp_mode = 2;
        settle(f_target(hint_async), "R9 random converge");

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule